// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives a multi-register memory transfer. Given a register bitmap, a base address, and a two-bit direction/timing code, it produces one transfer per clock. Each transfer carries a register index and a word address. Registers always go out in ascending index order, at ascending addresses, whichever way the base moves. After the last transfer it raises `done` for one cycle. During that cycle it presents the written-back base value and a flag that says whether the write-back may happen.

The sequencer also marks three special cases so that a neighbouring datapath can act on them:

- On a store, the slot for the base register may need the updated base value rather than the original one.
- A load that includes the program counter with the caret option must restore status.
- Any other caret transfer must use the user register bank.

Memory access, data movement and aborts are handled outside this block.

Top module: `multiXferSeq`

## Requirements
- R1: After reset, `busy`, `xferValid` and `done` are all 0.
- R2: A `start` sampled while idle launches one transfer per cycle, beginning the cycle after the start edge. `xferReg` visits every set bit of `regList` in ascending order.
- R3: `modeCode` bit 1 selects up (1) or down (0), and bit 0 selects before (1) or after (0). With n set bits and base B, the first address is:
  - B for code 2
  - B+4 for code 3
  - B-4n+4 for code 0
  - B-4n for code 1

  Each following transfer is 4 higher.
- R4: `done` is high for exactly one cycle, the cycle after the last transfer. For an empty list, `done` comes in the first cycle after the start edge and no transfer is issued.
- R5: While `done` is high, `newBase` equals B+4n for up codes and B-4n for down codes.
- R6: `wbEnable` is high during `done` exactly when write-back was requested and the base index is not 15.
- R7: `storeNewBase` is high on a transfer only when all of the following hold:
  - it is a store;
  - write-back applies (requested, and base index is not 15);
  - the transfer's index equals the base index;
  - that index is not the lowest set bit of the list.
- R8: `restoreStatus` is high only on the index-15 transfer of a load with caret set.
- R9: `userBank` is high on every transfer of a caret operation other than a load whose list contains index 15.
- R10: A `start` pulse while `busy` is high has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| regList | input | 16 | Register bitmap |
| baseAddr | input | 32 | Base address |
| baseIdx | input | 4 | Index of the base register |
| modeCode | input | 2 | Bit 1 up/down, bit 0 before/after |
| isLoad | input | 1 | 1 = load, 0 = store |
| writeBack | input | 1 | Base write-back requested |
| caretMode | input | 1 | Caret option |
| busy | output | 1 | Operation in progress |
| xferValid | output | 1 | A transfer is presented this cycle |
| xferReg | output | 4 | Register index of the transfer |
| xferAddr | output | 32 | Word address of the transfer |
| storeNewBase | output | 1 | Store the updated base in this slot |
| userBank | output | 1 | Use user-bank registers |
| restoreStatus | output | 1 | Restore status with this load |
| done | output | 1 | Sequence complete |
| newBase | output | 32 | Written-back base value |
| wbEnable | output | 1 | Write-back permitted |

## Verification
A wrong remaining-list register shows up at the ports on the very next transfer. It appears as a skipped or repeated index, or as `done` arriving one cycle early or late. A wrong captured start address or count corrupts every address of the operation and the `newBase` value in the `done` cycle. So a single operation with a known list exposes it within n+1 cycles. Errors in the latched option flags show on the base-register slot, on the index-15 slot, or on `wbEnable`. The bench aims directed cases at each of these slots.

// File: rtl/multiXferPkg.sv
package multiXferPkg;
  typedef enum logic [1:0] {
    MODE_DN_AFTER  = 2'b00,
    MODE_DN_BEFORE = 2'b01,
    MODE_UP_AFTER  = 2'b10,
    MODE_UP_BEFORE = 2'b11
  } xferMode_t;

  typedef struct packed {
    logic capture;
    logic advance;
  } seqStrobes_t;
endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import multiXferPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [LIST_W-1:0] regList,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        modeCode,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] newBase
);
  localparam int CNT_W = $clog2(LIST_W) + 1;

  logic [CNT_W-1:0]  setCount;
  logic [ADDR_W-1:0] span, lowAddr, startAddr, nextBase;

  always_comb begin
    setCount = '0;
    for (int i = 0; i < LIST_W; i++) setCount = setCount + CNT_W'(regList[i]);
  end

  assign span    = ADDR_W'(setCount) * ADDR_W'(WORD_BYTES);
  assign lowAddr = baseAddr - span;

  always_comb begin
    unique case (xferMode_t'(modeCode))
      MODE_UP_AFTER:  startAddr = baseAddr;
      MODE_UP_BEFORE: startAddr = baseAddr + ADDR_W'(WORD_BYTES);
      MODE_DN_AFTER:  startAddr = lowAddr + ADDR_W'(WORD_BYTES);
      default:        startAddr = lowAddr;
    endcase
    nextBase = modeCode[1] ? baseAddr + span : lowAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      newBase <= '0;
    end else if (strb.capture) begin
      curAddr <= startAddr;
      newBase <= nextBase;
    end else if (strb.advance) begin
      curAddr <= curAddr + ADDR_W'(WORD_BYTES);
    end
  end

  // R3: consecutive transfers step by one word
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !strb.capture |=> curAddr == $past(curAddr) + ADDR_W'(WORD_BYTES));
endmodule

// File: rtl/seqControl.sv
module seqControl
  import multiXferPkg::*;
#(
  parameter int LIST_W = 16,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LIST_W-1:0] regList,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic              isLoad,
  input  logic              writeBack,
  input  logic              caretMode,
  output seqStrobes_t       strb,
  output logic              busy,
  output logic              xferValid,
  output logic [IDX_W-1:0]  xferReg,
  output logic              storeNewBase,
  output logic              userBank,
  output logic              restoreStatus,
  output logic              done,
  output logic              wbEnable
);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(LIST_W - 1);

  logic [LIST_W-1:0] remList;
  logic [IDX_W-1:0]  baseR;
  logic              loadR, wbOkR, firstR, restoreR, userR;

  always_comb begin
    xferReg = '0;
    for (int i = LIST_W - 1; i >= 0; i--) if (remList[i]) xferReg = IDX_W'(i);
  end

  assign xferValid    = busy && (remList != '0);
  assign done         = busy && (remList == '0);
  assign strb.capture = start && !busy;
  assign strb.advance = xferValid;

  assign wbEnable      = done && wbOkR;
  assign storeNewBase  = xferValid && !loadR && wbOkR && !firstR && (xferReg == baseR);
  assign restoreStatus = xferValid && restoreR && (xferReg == PC_IDX);
  assign userBank      = xferValid && userR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      remList  <= '0;
      baseR    <= '0;
      loadR    <= 1'b0;
      wbOkR    <= 1'b0;
      firstR   <= 1'b0;
      restoreR <= 1'b0;
      userR    <= 1'b0;
    end else if (strb.capture) begin
      busy     <= 1'b1;
      remList  <= regList;
      baseR    <= baseIdx;
      loadR    <= isLoad;
      wbOkR    <= writeBack && (baseIdx != PC_IDX);
      firstR   <= 1'b1;
      restoreR <= caretMode && isLoad && regList[LIST_W-1];
      userR    <= caretMode && !(isLoad && regList[LIST_W-1]);
    end else if (strb.advance) begin
      remList <= remList & (remList - 1'b1);
      firstR  <= 1'b0;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  // R2: indices strictly ascend within a burst
  p_ascending_r2: assert property (@(posedge clk) disable iff (!rstN)
    xferValid && !strb.capture |=> !xferValid || xferReg > $past(xferReg));
  // R4: done lasts one cycle and ends the operation
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  // R8 / R9: status restore and user bank never coincide
  p_bank_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(userBank && restoreStatus));
  // R10: the list only shrinks while busy
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy && ((remList & ~$past(remList)) == '0));
endmodule

// File: rtl/multiXferSeq.sv
module multiXferSeq
  import multiXferPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LIST_W-1:0] regList,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic [1:0]        modeCode,
  input  logic              isLoad,
  input  logic              writeBack,
  input  logic              caretMode,
  output logic              busy,
  output logic              xferValid,
  output logic [IDX_W-1:0]  xferReg,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              storeNewBase,
  output logic              userBank,
  output logic              restoreStatus,
  output logic              done,
  output logic [ADDR_W-1:0] newBase,
  output logic              wbEnable
);
  seqStrobes_t strb;

  seqControl #(.LIST_W(LIST_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .regList(regList), .baseIdx(baseIdx),
    .isLoad(isLoad), .writeBack(writeBack), .caretMode(caretMode), .strb(strb),
    .busy(busy), .xferValid(xferValid), .xferReg(xferReg), .storeNewBase(storeNewBase),
    .userBank(userBank), .restoreStatus(restoreStatus), .done(done), .wbEnable(wbEnable)
  );

  seqDatapath #(.ADDR_W(ADDR_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regList(regList), .baseAddr(baseAddr),
    .modeCode(modeCode), .curAddr(xferAddr), .newBase(newBase)
  );
endmodule

// File: tb/multiXferSeq_tb_top.sv
module multiXferSeq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [15:0] regList = '0;
  logic [31:0] baseAddr = '0;
  logic [3:0]  baseIdx = '0;
  logic [1:0]  modeCode = '0;
  logic isLoad = 1'b0, writeBack = 1'b0, caretMode = 1'b0;
  logic busy, xferValid, storeNewBase, userBank, restoreStatus, done, wbEnable;
  logic [3:0]  xferReg;
  logic [31:0] xferAddr, newBase;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multiXferSeq dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int popCount(input logic [15:0] l);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(l[i]);
    return n;
  endfunction

  function automatic logic [31:0] firstAddr(input logic [31:0] b, input logic [1:0] m, input int n);
    case (m)
      2'd2:    return b;
      2'd3:    return b + 32'd4;
      2'd0:    return b - 32'(4*n) + 32'd4;
      default: return b - 32'(4*n);
    endcase
  endfunction

  task automatic runOp(input logic [15:0] l, input logic [31:0] b, input logic [3:0] bi,
                       input logic [1:0] m, input logic ld, input logic wb,
                       input logic ct, input bit poke);
    int n = popCount(l);
    logic [31:0] a = firstAddr(b, m, n);
    int lowest = -1;
    logic wbOk = wb && (bi != 4'd15);
    logic expUser = ct && !(ld && l[15]);
    for (int i = 15; i >= 0; i--) if (l[i]) lowest = i;
    regList = l; baseAddr = b; baseIdx = bi; modeCode = m;
    isLoad = ld; writeBack = wb; caretMode = ct; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < 16; r++) begin
      if (!l[r]) continue;
      if (poke) begin  // R10: a start while busy with other operands
        start = 1'b1; regList = 16'h0001; baseAddr = 32'h0; modeCode = 2'd0;
        poke = 1'b0;
      end
      chk("R2 valid", 32'(xferValid), 32'd1);
      chk("R2 reg", 32'(xferReg), 32'(r));
      chk("R3 addr", xferAddr, a);
      chk("R7 storeNewBase", 32'(storeNewBase),
          32'(!ld && wbOk && (r == int'(bi)) && (r != lowest)));
      chk("R8 restore", 32'(restoreStatus), 32'(ct && ld && r == 15));
      chk("R9 userBank", 32'(userBank), 32'(expUser));
      a += 32'd4;
      @(negedge clk);
      start = 1'b0;
    end
    chk("R4 done", 32'(done), 32'd1);
    chk("R4 no xfer at done", 32'(xferValid), 32'd0);
    chk("R5 newBase", newBase, m[1] ? b + 32'(4*n) : b - 32'(4*n));
    chk("R6 wbEnable", 32'(wbEnable), 32'(wbOk));
    @(negedge clk);
    chk("R4 done once", 32'(done), 32'd0);
    chk("R10 idle after", 32'(busy), 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 valid", 32'(xferValid), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        rstN = 1'b1;
        @(negedge clk);
        // R4: empty list, all modes
        for (int m = 0; m < 4; m++) runOp(16'h0000, 32'h1000, 4'd3, 2'(m), 1'b0, 1'b1, 1'b0, 1'b0);
        // full list, all modes
        for (int m = 0; m < 4; m++) runOp(16'hFFFF, 32'h8000, 4'd13, 2'(m), 1'b1, 1'b1, 1'b0, 1'b0);
        // R7: base lowest vs not lowest
        runOp(16'h00F0, 32'h2000, 4'd4, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        runOp(16'h00F0, 32'h2000, 4'd6, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        runOp(16'h00F0, 32'h2000, 4'd6, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R6: base 15 suppresses write-back
        runOp(16'h8006, 32'h3000, 4'd15, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        // R8 / R9: caret variants
        runOp(16'h8003, 32'h4000, 4'd13, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        runOp(16'h8003, 32'h4000, 4'd13, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
        runOp(16'h0C03, 32'h4000, 4'd13, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        // R10: start ignored while busy
        runOp(16'h1248, 32'h5000, 4'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1);
        // constrained random
        void'($urandom(32'd4242));
        for (int k = 0; k < 60; k++)
          runOp(16'($urandom), {$urandom} & 32'hFFFF_FFFC, 4'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0);
      end
      begin
        repeat (50000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule